// File: doc/BRIEF.md
# Asynchronous Handshake Read Link

This block joins a read requester and a memory responder that run on unrelated clocks. They share one set of data lines and three control wires: a read request, a data-ready strobe and an acknowledge. Both sides can drive the acknowledge wire, and the wire reads as the OR of the two. A read takes seven steps. The requester puts the address on the shared lines and raises the request in the same cycle. The responder captures the address and raises acknowledge. The requester withdraws the request and the address. The responder drops acknowledge and starts its access. When the word is ready, the responder drives it onto the same lines and raises data-ready. The requester latches the word and raises acknowledge. The responder withdraws data-ready and the data. Finally the requester drops acknowledge.

Each side passes every control wire it watches through a two-flop synchroniser before its state machine acts on it. The responder holds a behavioural memory array that is loaded at reset with a computed pattern. Its access time is a parameter counted in its own clock cycles. A local user starts a read with a one-cycle start pulse while `ready` is high. A one-cycle `done` pulse then marks the end of the exchange, and `rd_data` holds the returned word.

Top module: `async_read_link`

## Requirements
- R1: While reset is asserted and just after it, read request, data-ready and acknowledge are low, neither side drives the shared lines, `done` is low and `ready` is high.
- R2: The same requester clock edge that raises the read request also starts driving the start address, zero-extended, onto the shared lines.
- R3: The requester lowers the read request only while acknowledge is high, and it stops driving the shared lines in the same cycle.
- R4: After the responder lowers acknowledge, data-ready rises exactly max(LAT,3) responder clock cycles later. At that moment the read request and acknowledge are low and the responder drives the lines.
- R5: The word returned in `rd_data` equals the memory pattern at the requested address: ((addr*29) XOR 0xA5) modulo 256.
- R6: The requester raises acknowledge after data-ready. The responder lowers data-ready only after acknowledge is high. The pulse on `done` comes when acknowledge returns low, and at that time data-ready and the read request are low.
- R7: The requester and the responder never drive the shared lines at the same time.
- R8: A new read request rises only while acknowledge is low. `ready` is low while acknowledge is high. A start pulse given while `ready` is low is ignored and starts no read.
- R9: Each handshake input is synchronised through two flops. The responder's acknowledge rises 2 to 3 responder clock cycles after the read request is first seen high at a falling responder clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_req | input | 1 | Requester clock |
| clk_mem | input | 1 | Responder clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| start | input | 1 | One-cycle pulse that starts a read (clk_req) |
| start_addr | input | AW | Address of the read |
| ready | output | 1 | Requester can accept a start |
| done | output | 1 | One-cycle pulse at the end of a read |
| rd_data | output | DW | Word returned by the last read |
| read_req | output | 1 | Read request wire |
| data_rdy | output | 1 | Data-ready wire |
| ack | output | 1 | Shared acknowledge wire (OR of both sides) |
| bus_lines | output | DW | Shared address/data lines |
| req_drives | output | 1 | Requester drives the shared lines |
| mem_drives | output | 1 | Responder drives the shared lines |

## Verification
The two acknowledge phases can fall close together. The responder's acknowledge for the request is still in its synchroniser when it must judge the requester's acknowledge for the data. At short latency, a stale high could then retire data-ready early. The bench provokes this by sweeping all sixteen addresses with back-to-back reads and varying gaps, and it measures the interval from acknowledge fall to data-ready rise in responder cycles. The bench also pulses start during the acknowledge-high phase. There the ready gating and the FSM's own gating act in the same cycle, and the bench judges the result by checking that no stray read follows.

// File: rtl/async_rd_pkg.sv
package async_rd_pkg;

  typedef enum logic [1:0] {RQ_IDLE, RQ_ADDR, RQ_WAIT, RQ_FIN} rq_state_t;
  typedef enum logic [1:0] {RS_IDLE, RS_ACK, RS_ACCESS, RS_DRIVE} rs_state_t;

  // Memory fill pattern: word at address a
  function automatic logic [31:0] fill_word(input int unsigned a);
    return 32'(((a * 29) ^ 32'hA5) & 32'hFF);
  endfunction

  // Responder cycles from ack fall to data-ready rise
  function automatic int unsigned ready_delay(input int unsigned lat);
    return (lat < 3) ? 3 : lat;
  endfunction

endpackage

// File: rtl/hs_sync2.sv
module hs_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hs_requester.sv
module hs_requester
  import async_rd_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          ack_line,
  input  logic          rdy_line,
  input  logic [DW-1:0] bus_in,
  output logic          read_req,
  output logic          ack_req,
  output logic          drive_en,
  output logic [DW-1:0] drive_val,
  output logic [DW-1:0] rd_data,
  output logic          done,
  output logic          ready,
  output logic          ev_latch
);
  rq_state_t     state;
  logic [AW-1:0] addr_q;
  logic          ack_s, rdy_s;

  hs_sync2 #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ack_line, rdy_line}),
    .q({ack_s, rdy_s})
  );

  assign ready     = (state == RQ_IDLE) && !ack_s;
  assign ev_latch  = (state == RQ_WAIT) && rdy_s;
  assign drive_val = DW'(addr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RQ_IDLE;
      addr_q   <= '0;
      read_req <= 1'b0;
      ack_req  <= 1'b0;
      drive_en <= 1'b0;
      rd_data  <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        RQ_IDLE: if (start && ready) begin
          addr_q   <= start_addr;
          read_req <= 1'b1;
          drive_en <= 1'b1;
          state    <= RQ_ADDR;
        end
        RQ_ADDR: if (ack_s) begin
          read_req <= 1'b0;
          drive_en <= 1'b0;
          state    <= RQ_WAIT;
        end
        RQ_WAIT: if (ev_latch) begin
          rd_data <= bus_in;
          ack_req <= 1'b1;
          state   <= RQ_FIN;
        end
        RQ_FIN: if (!rdy_s) begin
          ack_req <= 1'b0;
          done    <= 1'b1;
          state   <= RQ_IDLE;
        end
        default: state <= RQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hs_responder.sv
module hs_responder
  import async_rd_pkg::*;
#(
  parameter int AW  = 4,
  parameter int DW  = 8,
  parameter int LAT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_line,
  input  logic          ack_line,
  input  logic [DW-1:0] bus_in,
  output logic          ack_mem,
  output logic          data_rdy,
  output logic          drive_en,
  output logic [DW-1:0] drive_val,
  output logic          ev_capture
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(LAT + 1);
  localparam logic [CW-1:0] LAST = CW'(LAT - 1);

  rs_state_t     state;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt;
  logic [DW-1:0] mem [DEPTH];
  logic          req_s, ack_s, access_end;

  hs_sync2 #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({req_line, ack_line}),
    .q({req_s, ack_s})
  );

  assign ev_capture = (state == RS_IDLE) && req_s;
  // Own ack must have cleared the synchroniser before data-ready goes out
  assign access_end = (state == RS_ACCESS) && (cnt == LAST) && !ack_s;

  for (genvar i = 0; i < DEPTH; i++) begin : g_mem
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[i] <= DW'(fill_word(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RS_IDLE;
      addr_q    <= '0;
      cnt       <= '0;
      ack_mem   <= 1'b0;
      data_rdy  <= 1'b0;
      drive_en  <= 1'b0;
      drive_val <= '0;
    end else begin
      unique case (state)
        RS_IDLE: if (ev_capture) begin
          addr_q  <= bus_in[AW-1:0];
          ack_mem <= 1'b1;
          state   <= RS_ACK;
        end
        RS_ACK: if (!req_s) begin
          ack_mem <= 1'b0;
          cnt     <= '0;
          state   <= RS_ACCESS;
        end
        RS_ACCESS: begin
          if (access_end) begin
            drive_val <= mem[addr_q];
            data_rdy  <= 1'b1;
            drive_en  <= 1'b1;
            state     <= RS_DRIVE;
          end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
          end
        end
        RS_DRIVE: if (ack_s) begin
          data_rdy <= 1'b0;
          drive_en <= 1'b0;
          state    <= RS_IDLE;
        end
        default: state <= RS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/async_read_link.sv
module async_read_link #(
  parameter int AW  = 4,
  parameter int DW  = 8,
  parameter int LAT = 4
) (
  input  logic          clk_req,
  input  logic          clk_mem,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  output logic          ready,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          read_req,
  output logic          data_rdy,
  output logic          ack,
  output logic [DW-1:0] bus_lines,
  output logic          req_drives,
  output logic          mem_drives
);
  logic          ack_req, ack_mem;
  logic [DW-1:0] req_val, mem_val;
  logic          ev_latch, ev_capture;

  // Wired-OR acknowledge and shared lines (idle lines read as zero)
  assign ack       = ack_req | ack_mem;
  assign bus_lines = req_drives ? req_val : (mem_drives ? mem_val : '0);

  hs_requester #(.AW(AW), .DW(DW)) u_req (
    .clk(clk_req), .rst_n(rst_n),
    .start(start), .start_addr(start_addr),
    .ack_line(ack), .rdy_line(data_rdy), .bus_in(bus_lines),
    .read_req(read_req), .ack_req(ack_req),
    .drive_en(req_drives), .drive_val(req_val),
    .rd_data(rd_data), .done(done), .ready(ready), .ev_latch(ev_latch)
  );

  hs_responder #(.AW(AW), .DW(DW), .LAT(LAT)) u_mem (
    .clk(clk_mem), .rst_n(rst_n),
    .req_line(read_req), .ack_line(ack), .bus_in(bus_lines),
    .ack_mem(ack_mem), .data_rdy(data_rdy),
    .drive_en(mem_drives), .drive_val(mem_val), .ev_capture(ev_capture)
  );
endmodule

// File: rtl/async_read_link_chk.sv
module async_read_link_chk (
  input logic clk_req,
  input logic clk_mem,
  input logic rst_n,
  input logic read_req,
  input logic data_rdy,
  input logic ack,
  input logic req_drives,
  input logic mem_drives,
  input logic done,
  input logic ready
);
  AST_NO_CONTENTION: assert property (@(posedge clk_mem) disable iff (!rst_n)
    !(req_drives && mem_drives)); // R7
  AST_ADDR_WITH_REQ: assert property (@(posedge clk_req) disable iff (!rst_n)
    $rose(read_req) |-> req_drives); // R2
  AST_WITHDRAW_ON_ACK: assert property (@(posedge clk_req) disable iff (!rst_n)
    $fell(read_req) |-> ($past(ack) && !req_drives)); // R3
  AST_DATA_AFTER_GAP: assert property (@(posedge clk_mem) disable iff (!rst_n)
    $rose(data_rdy) |-> (!read_req && !ack && mem_drives)); // R4
  AST_RDY_DROP_ON_ACK: assert property (@(posedge clk_mem) disable iff (!rst_n)
    $fell(data_rdy) |-> $past(ack)); // R6
  AST_DONE_QUIET: assert property (@(posedge clk_req) disable iff (!rst_n)
    done |-> (!data_rdy && !read_req)); // R6
  AST_NEW_REQ_ACK_LOW: assert property (@(posedge clk_req) disable iff (!rst_n)
    $rose(read_req) |-> !ack); // R8
  AST_NOT_READY_ON_ACK: assert property (@(posedge clk_req) disable iff (!rst_n)
    (ack && $past(ack) && $past(ack, 2)) |-> !ready); // R8
endmodule

bind async_read_link async_read_link_chk u_chk (
  .clk_req(clk_req), .clk_mem(clk_mem), .rst_n(rst_n),
  .read_req(read_req), .data_rdy(data_rdy), .ack(ack),
  .req_drives(req_drives), .mem_drives(mem_drives),
  .done(done), .ready(ready)
);

// File: tb/async_read_link_test.sv
module async_read_link_test;
  localparam int REQ_PERIOD = 10;
  localparam int MEM_PERIOD = 14;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int LAT = 4;
  localparam int GAP = (LAT < 3) ? 3 : LAT;

  logic clk_req = 1'b0, clk_mem = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic ready, done, read_req, data_rdy, ack, req_drives, mem_drives;
  logic [DW-1:0] rd_data, bus_lines;

  int checks = 0, errors = 0;
  logic [DW-1:0] cur_addr = '0;
  logic clash_seen = 1'b0;
  bit finished = 1'b0;

  always #(REQ_PERIOD/2) clk_req = ~clk_req;
  always #(MEM_PERIOD/2) clk_mem = ~clk_mem;

  async_read_link #(.AW(AW), .DW(DW), .LAT(LAT)) uut (
    .clk_req(clk_req), .clk_mem(clk_mem), .rst_n(rst_n),
    .start(start), .start_addr(start_addr),
    .ready(ready), .done(done), .rd_data(rd_data),
    .read_req(read_req), .data_rdy(data_rdy), .ack(ack),
    .bus_lines(bus_lines), .req_drives(req_drives), .mem_drives(mem_drives)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] expect_word(input int a);
    int m = (a << 4) + (a << 3) + (a << 2) + a;
    return DW'((m & 255) ^ 8'b1010_0101);
  endfunction

  // Responder-side timing monitor
  int mcyc = 0, t_req = 0, t_fall = 0;
  bit p_req = 0, p_ack = 0, p_rdy = 0, mem_ack_phase = 0;
  always @(negedge clk_mem) begin
    mcyc++;
    if (req_drives && mem_drives) clash_seen = 1'b1;
    if (rst_n) begin
      if (read_req && !p_req) t_req = mcyc;
      if (ack && !p_ack && !data_rdy) begin
        check((mcyc - t_req) >= 2 && (mcyc - t_req) <= 3, "R9", mcyc - t_req, 2);
        mem_ack_phase = 1;
      end
      if (!ack && p_ack && mem_ack_phase) begin
        t_fall = mcyc;
        mem_ack_phase = 0;
      end
      if (data_rdy && !p_rdy) check((mcyc - t_fall) == GAP, "R4", mcyc - t_fall, GAP);
    end
    p_req = read_req; p_ack = ack; p_rdy = data_rdy;
  end

  // Requester-side monitor
  bit q_req = 0;
  always @(negedge clk_req) begin
    if (req_drives && mem_drives) clash_seen = 1'b1;
    if (rst_n) begin
      if (read_req && !q_req) begin
        check(req_drives && bus_lines == cur_addr, "R2", int'(bus_lines), int'(cur_addr));
        check(!ack, "R8", ack, 0);
      end
      if (!read_req && q_req) check(!req_drives && ack, "R3", {req_drives, ack}, 1);
    end
    q_req = read_req;
  end

  task automatic do_read(input int a, input int gap, input bit poke);
    while (!ready) @(negedge clk_req);
    repeat (gap) @(negedge clk_req);
    cur_addr = DW'(a);
    start_addr = AW'(a);
    start = 1'b1;
    @(negedge clk_req);
    start = 1'b0;
    if (poke) begin
      while (!ack) @(negedge clk_req);
      check(!ready, "R8", ready, 0);
      start_addr = AW'(a + 1);
      start = 1'b1;
      @(negedge clk_req);
      start = 1'b0;
    end
    while (!done) @(negedge clk_req);
    check(rd_data == expect_word(a), "R5", int'(rd_data), int'(expect_word(a)));
    check(!ack && !data_rdy && !read_req, "R6", {ack, data_rdy, read_req}, 0);
    check(!clash_seen, "R7", clash_seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_req);
    check(!read_req && !data_rdy && !ack && !req_drives && !mem_drives && !done && ready,
          "R1", {read_req, data_rdy, ack, req_drives, mem_drives, done, ready}, 1);
    rst_n = 1'b1;
    @(negedge clk_req);
    check(ready && !read_req && !ack && bus_lines == '0, "R1", int'(bus_lines), 0);

    for (int a = 0; a < (1 << AW); a++) do_read(a, a % 3, 1'b0);
    for (int a = (1 << AW) - 1; a >= 0; a -= 5) do_read(a, 0, 1'b0);

    // Start pulse while acknowledge is high must not begin a second read
    do_read(6, 1, 1'b1);
    repeat (40) @(negedge clk_req);
    check(!read_req && !done && rd_data == expect_word(6), "R8", int'(rd_data), int'(expect_word(6)));

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_req);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule